// File: doc/BRIEF.md
# Word-to-Bit Serializer with Word-Rate Clock Divider

This block turns parallel words into a single bit-serial stream for an optical line interface. A word is 8 bits in wide mode. In narrow mode it is 4 bits, carried on the upper half of the bus. Words are captured on the rising edge of a parallel-side clock into a small ring of holding slots. A counter in the bit-clock domain pulls them out one per word period and shifts each one out most significant bit first.

The same counter produces a divided clock at the word rate: the bit clock divided by 8 in wide mode and by 4 in narrow mode. Upstream logic can use it to time its parallel transfers. The parallel clock may have any phase relative to the bit clock. The active-low master reset aligns the two domains. After release, the bit-clock side waits a fixed number of word periods before its first load, so a word captured on the first parallel-clock edge is always complete when it is read.

Top module: `ser_wordpath`

## Requirements
- R1: With `bus_wide` high, each word is sent as 8 serial bits on `sdo`, bit 7 first and bit 0 last, one bit per rising edge of `bclk`.
- R2: With `bus_wide` low, each word is sent as 4 serial bits, in the order `pdata[7]`, `pdata[6]`, `pdata[5]`, `pdata[4]`.
- R3: With `bus_wide` low, `pdata[3:0]` has no effect on `sdo`.
- R4: `dclk` has a period of N bit-clock cycles, where N is 8 with `bus_wide` high and 4 with it low. After the e-th rising edge of `bclk` following reset release, `dclk` is high exactly when (e mod N) is N/2 or more.
- R5: While `rst_n` is low, `dclk` and `sdo` are both low.
- R6: `sdo` stays low up to the 2N-th rising edge of `bclk` after reset release. The first load happens at edge 2N, and later loads follow every N edges.
- R7: Words leave in capture order. The word captured on the k-th parallel-clock rising edge after release (k counted from 0) is loaded at bit-clock edge (k+2)·N. None is skipped or repeated, for any parallel-clock phase whose first edge falls within the first N-1 bit periods after release.
- R8: Each load happens on the same bit-clock edge where `dclk` falls, and `sdo` then shows the new word's first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Parallel-side word clock; data is sampled on its rising edge |
| pdata | input | 8 | Parallel word; bit 7 is sent first |
| bus_wide | input | 1 | Word size select: high for 8-bit words, low for 4-bit words on bits 7..4 |
| rst_n | input | 1 | Active-low master reset for both clock domains |
| bclk | input | 1 | Serial bit clock |
| sdo | output | 1 | Serial data out |
| dclk | output | 1 | Bit clock divided to the word rate; low during reset |

## Verification
The bench builds the block with its defaults: an 8-bit word and two holding slots. With these defaults both word sizes can be selected at run time from the same build, and the two-slot read lag of one word period is the case that actually runs. Each bus width is run twice. Each run starts the parallel clock at a random whole number of bit periods plus a random fraction of a period after reset release, so capture lands both early and late within the allowed window. Narrow-mode runs fill the lower nibble with random values, so any leak of those bits into the stream shows up as a mismatch.

// File: rtl/ser_pkg.sv
package ser_pkg;

   typedef enum logic {
      BUS_NARROW = 1'b0,
      BUS_WIDE   = 1'b1
   } bus_mode_e;

   // Number of serial bits per word for a given mode and full width.
   function automatic int unsigned bits_per_word(input logic wide, input int unsigned full_w);
      return wide ? full_w : full_w / 2;
   endfunction

endpackage

// File: rtl/ser_hold.sv
module ser_hold #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned SLOTS  = 2
) (
   input  logic                           pclk,
   input  logic                           rst_n,
   input  logic                           wide,
   input  logic [WORD_W-1:0]              pdata,
   output logic [SLOTS-1:0][WORD_W-1:0]   slots_o
);
   import ser_pkg::*;

   localparam int unsigned PTR_W = $clog2(SLOTS);
   localparam int unsigned HALF  = WORD_W / 2;

   logic [WORD_W-1:0] masked;
   logic [PTR_W-1:0]  wr_ptr;

   // Lower half of the word only passes through in wide mode.
   for (genvar i = 0; i < WORD_W; i++) begin : g_mask
      if (i >= HALF) begin : g_upper
         assign masked[i] = pdata[i];
      end else begin : g_lower
         assign masked[i] = pdata[i] & (wide == BUS_WIDE);
      end
   end

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n) begin
         slots_o <= '0;
         wr_ptr  <= '0;
      end else begin
         slots_o[wr_ptr] <= masked;
         wr_ptr          <= wr_ptr + PTR_W'(1);
      end
   end

   // R3: a narrow-mode capture carries nothing in the lower half.
   assert_low_ignored_R3: assert property (@(posedge pclk) disable iff (!rst_n)
      !wide |=> (slots_o[$past(wr_ptr)][HALF-1:0] == '0));

endmodule

// File: rtl/ser_divider.sv
module ser_divider #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned SLOTS  = 2
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic wide,
   output logic load_o,
   output logic primed_o,
   output logic dclk_o
);
   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam int unsigned PW    = $clog2(SLOTS);
   localparam logic [CNT_W-1:0] LIM_WIDE    = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] LIM_NARROW  = CNT_W'(WORD_W / 2 - 1);
   localparam logic [CNT_W-1:0] HALF_WIDE   = CNT_W'(WORD_W / 2);
   localparam logic [CNT_W-1:0] HALF_NARROW = CNT_W'(WORD_W / 4);
   localparam logic [PW-1:0]    PRIME_WRAPS = PW'(SLOTS - 1);

   logic [CNT_W-1:0] cnt, cnt_nx, lim, half;
   logic [PW-1:0]    wraps;
   logic             at_end;

   assign lim      = wide ? LIM_WIDE  : LIM_NARROW;
   assign half     = wide ? HALF_WIDE : HALF_NARROW;
   assign at_end   = (cnt == lim);
   assign cnt_nx   = at_end ? '0 : cnt + CNT_W'(1);
   assign primed_o = (wraps == PRIME_WRAPS);
   assign load_o   = primed_o && at_end;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         wraps  <= '0;
         dclk_o <= 1'b0;
      end else begin
         cnt    <= cnt_nx;
         dclk_o <= (cnt_nx >= half);
         if (at_end && !primed_o) wraps <= wraps + PW'(1);
      end
   end

   // R4: the phase counter never leaves the word length.
   assert_cnt_range_R4: assert property (@(posedge bclk) disable iff (!rst_n)
      cnt <= lim);
   // R8: every load coincides with a falling edge of the divided clock.
   assert_load_on_fall_R8: assert property (@(posedge bclk) disable iff (!rst_n)
      load_o |=> $fell(dclk_o));

endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned SLOTS  = 2
) (
   input  logic                         bclk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic [SLOTS-1:0][WORD_W-1:0] slots_i,
   output logic                         sdo_o
);
   localparam int unsigned PTR_W = $clog2(SLOTS);

   logic [PTR_W-1:0]  rd_ptr;
   logic [WORD_W-1:0] sh;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         sh     <= '0;
      end else if (load_i) begin
         sh     <= slots_i[rd_ptr];
         rd_ptr <= rd_ptr + PTR_W'(1);
      end else begin
         sh     <= {sh[WORD_W-2:0], 1'b0};
      end
   end

   assign sdo_o = sh[WORD_W-1];

   // R1: a load puts the word's top bit on the line first.
   assert_msb_first_R1: assert property (@(posedge bclk) disable iff (!rst_n)
      load_i |=> (sdo_o == $past(slots_i[rd_ptr][WORD_W-1])));

endmodule

// File: rtl/ser_wordpath.sv
module ser_wordpath #(
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned HOLD_SLOTS = 2
) (
   input  logic              pclk,
   input  logic [WORD_W-1:0] pdata,
   input  logic              bus_wide,
   input  logic              rst_n,
   input  logic              bclk,
   output logic              sdo,
   output logic              dclk
);
   localparam bit SLOTS_POW2 = (HOLD_SLOTS & (HOLD_SLOTS - 1)) == 0;

   if (WORD_W < 4 || (WORD_W % 4) != 0) begin : g_bad_width
      $error("ser_wordpath: WORD_W must be a multiple of 4");
   end
   if (HOLD_SLOTS < 2 || !SLOTS_POW2) begin : g_bad_slots
      $error("ser_wordpath: HOLD_SLOTS must be a power of two of at least 2");
   end

   logic [HOLD_SLOTS-1:0][WORD_W-1:0] slots;
   logic load, primed;

   ser_hold #(.WORD_W(WORD_W), .SLOTS(HOLD_SLOTS)) u_hold (
      .pclk    (pclk),
      .rst_n   (rst_n),
      .wide    (bus_wide),
      .pdata   (pdata),
      .slots_o (slots)
   );

   ser_divider #(.WORD_W(WORD_W), .SLOTS(HOLD_SLOTS)) u_div (
      .bclk     (bclk),
      .rst_n    (rst_n),
      .wide     (bus_wide),
      .load_o   (load),
      .primed_o (primed),
      .dclk_o   (dclk)
   );

   ser_shift #(.WORD_W(WORD_W), .SLOTS(HOLD_SLOTS)) u_shift (
      .bclk    (bclk),
      .rst_n   (rst_n),
      .load_i  (load),
      .slots_i (slots),
      .sdo_o   (sdo)
   );

   // R6: nothing reaches the line before the first load.
   assert_idle_low_R6: assert property (@(posedge bclk) disable iff (!rst_n)
      !primed |-> !sdo);

endmodule

// File: tb/sim_ser_wordpath.sv
module sim_ser_wordpath;

   logic       pclk = 1'b0;
   logic [7:0] pdata = '0;
   logic       bus_wide = 1'b1;
   logic       rst_n = 1'b0;
   logic       bclk = 1'b0;
   logic       sdo, dclk;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit active = 1'b0;
   int edge_cnt = 0;
   int run_nw = 0;
   logic [7:0] sent[$];

   always #10 bclk = ~bclk;

   ser_wordpath u0 (
      .pclk(pclk), .pdata(pdata), .bus_wide(bus_wide), .rst_n(rst_n),
      .bclk(bclk), .sdo(sdo), .dclk(dclk)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] masked(input logic [7:0] w, input logic wide);
      return wide ? w : {w[7:4], 4'b0000};
   endfunction

   always @(posedge bclk) if (rst_n && active) edge_cnt++;

   // Reference model, compared once per bit period away from the edge.
   always @(negedge bclk) begin
      if (active && edge_cnt > 0) begin
         int n, e, k, b, exp_sdo, exp_dclk;
         n = bus_wide ? 8 : 4;
         e = edge_cnt;
         exp_dclk = ((e % n) >= n / 2) ? 1 : 0;
         check(dclk == exp_dclk, "R4 divided clock", int'(dclk), exp_dclk);
         if (e < 2 * n) begin
            check(sdo == 1'b0, "R6 idle before first load", int'(sdo), 0);
         end else begin
            k = e / n - 2;
            b = e % n;
            if (k < run_nw) begin
               if (k >= sent.size()) begin
                  check(1'b0, "R7 word not yet captured", k, sent.size());
               end else begin
                  exp_sdo = int'(sent[k][7 - b]);
                  if (bus_wide)
                     check(sdo == exp_sdo, "R1 R7 wide serial bit", int'(sdo), exp_sdo);
                  else
                     check(sdo == exp_sdo, "R2 R3 R7 narrow serial bit", int'(sdo), exp_sdo);
                  if (b == 0) begin
                     check(dclk == 1'b0, "R8 load on dclk fall", int'(dclk), 0);
                     check(sdo == exp_sdo, "R8 first bit at load", int'(sdo), exp_sdo);
                  end
               end
            end
         end
      end
   end

   task automatic run_mode(input logic wide, input int nw);
      int n, p, skip, phase;
      logic [7:0] w;
      n = wide ? 8 : 4;
      p = n * 20;
      active = 1'b0;
      rst_n = 1'b0;
      pclk = 1'b0;
      bus_wide = wide;
      run_nw = nw;
      edge_cnt = 0;
      sent.delete();
      repeat (3) begin
         @(negedge bclk);
         check(dclk == 1'b0, "R5 dclk low in reset", int'(dclk), 0);
         check(sdo == 1'b0, "R5 sdo low in reset", int'(sdo), 0);
      end
      @(negedge bclk);
      rst_n = 1'b1;
      active = 1'b1;
      skip = int'($urandom_range(n - 2, 0));
      phase = int'($urandom_range(16, 2));
      repeat (skip) @(posedge bclk);
      #(phase);
      for (int i = 0; i < nw; i++) begin
         case (i)
            0: w = 8'hA5;
            1: w = 8'hFF;
            2: w = 8'h00;
            3: w = 8'h81;
            4: w = 8'h3C;
            5: w = 8'h0F;
            default: w = 8'($urandom);
         endcase
         pdata = w;
         #1 pclk = 1'b1;
         sent.push_back(masked(w, wide));
         #(p / 2) pclk = 1'b0;
         #(p / 2 - 1);
      end
      while (edge_cnt < (nw + 2) * n + 2) @(negedge bclk);
      active = 1'b0;
   endtask

   initial begin
      run_mode(1'b1, 12);
      run_mode(1'b1, 12);
      run_mode(1'b0, 12);
      run_mode(1'b0, 12);
      rst_n = 1'b0;
      @(negedge bclk);
      check(dclk == 1'b0 && sdo == 1'b0, "R5 final reset", int'({dclk, sdo}), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule